// File: doc/BRIEF.md
# Dual-modulus 16/17 clock prescaler

This block divides its input clock by 16 or by 17, picked by one mode bit. A front stage normally divides by 2. A three-stage divide-by-8 chain counts the front-stage periods. Once per output period, in the last front-stage period, the front stage may stretch to a single divide-by-3 step. That step is allowed only when the 17 mode was captured for the current period. Because the stretch can never occur twice in a row, the front stage is gated by a single AND term of the mode and a chain-state decode.

All flip-flops run on the input clock. The chain advances on a clock enable taken from the front-stage terminal count, so there is no ripple clocking. The divided clock is the most significant chain stage. It is high for 8 input clocks and then low for 8 clocks (divide by 16) or 9 clocks (divide by 17). A one-clock strobe marks the first cycle of each output period, for use by an external swallow counter.

Top module: `dmp_prescaler`

## Requirements
- R1: While rst_ni is low, div_o and period_o are both 1. Reset takes effect asynchronously, including in the middle of a period.
- R2: When the captured mode bit is 0, consecutive rising edges of div_o are exactly 16 input clocks apart.
- R3: When the captured mode bit is 1, consecutive rising edges of div_o are exactly 17 input clocks apart.
- R4: div_o stays high for exactly 8 input clocks in every period, in both modes.
- R5: div_o stays low for 8 input clocks in the 16 mode and 9 input clocks in the 17 mode.
- R6: mc_i is sampled only on the clock edge that ends the first cycle of an output period, which is the cycle in which period_o is 1. A change at any later point in the period takes effect from the next period.
- R7: period_o is 1 for exactly one input clock per period. That clock is the first cycle in which div_o is 1 after being 0.
- R8: The first output period after reset release already has the length selected by mc_i. That first period begins in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mc_i | input | 1 | Modulus select: 0 divides by 16, 1 divides by 17 |
| div_o | output | 1 | Divided clock |
| period_o | output | 1 | One-clock strobe at the start of each output period |

## Verification
div_o and period_o are decoded straight from registers. They therefore change only just after a clock edge, and the first period after release begins in the cycle that follows reset release. mc_i counts for a period only if it is stable at the edge that ends that period's strobe cycle. The bench therefore drives mc_i on the falling edge inside the strobe cycle, or later in the period to test deferral. The bench samples both outputs on falling edges and counts cycles from one strobe to the next, split into high and low time. It compares those counts with 16 or 17, and with 8 high plus 8 or 9 low, for the mode driven at the start of that period.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  parameter int unsigned DMP_STAGES = 3;

  typedef enum logic [1:0] {
    FE_HEAD = 2'd0,
    FE_EXT  = 2'd1,
    FE_TAIL = 2'd2
  } fe_state_e;
endpackage

// File: rtl/dmp_front.sv
// Pseudo 2/3 front stage: HEAD->TAIL normally, HEAD->EXT->TAIL when stretched.
module dmp_front
  import dmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic head_o,
  output logic tc_o
);
  fe_state_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      FE_HEAD: st_d = ext_i ? FE_EXT : FE_TAIL;
      FE_EXT:  st_d = FE_TAIL;
      default: st_d = FE_HEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FE_HEAD;
    else         st_q <= st_d;
  end

  assign head_o = (st_q == FE_HEAD);
  assign tc_o   = (st_q == FE_TAIL);
endmodule

// File: rtl/dmp_chain.sv
// Down-counting chain of toggle stages, enabled by the front terminal count.
module dmp_chain #(
  parameter int unsigned STAGES = dmp_pkg::DMP_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] tog;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_lsb
      assign tog[i] = adv_i;
    end else begin : g_upper
      assign tog[i] = adv_i & ~(|q_q[i-1:0]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q[i] <= 1'b1;
      else if (tog[i]) q_q[i] <= ~q_q[i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dmp_modctl.sv
// Mode capture at period start; stretch only in the all-zero chain state.
module dmp_modctl #(
  parameter int unsigned STAGES = dmp_pkg::DMP_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_i,
  input  logic              start_i,
  input  logic [STAGES-1:0] chain_i,
  output logic              ext_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 1'b0;
    else if (start_i) mode_q <= mc_i;
  end

  assign ext_o = mode_q & ~(|chain_i);
endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler #(
  parameter int unsigned STAGES = dmp_pkg::DMP_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mc_i,
  output logic div_o,
  output logic period_o
);
  logic              ext;
  logic              head;
  logic              tc;
  logic [STAGES-1:0] chain_q;

  dmp_front u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext),
    .head_o (head),
    .tc_o   (tc)
  );

  dmp_chain #(.STAGES(STAGES)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (tc),
    .q_o    (chain_q)
  );

  dmp_modctl #(.STAGES(STAGES)) u_modctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mc_i    (mc_i),
    .start_i (period_o),
    .chain_i (chain_q),
    .ext_o   (ext)
  );

  assign period_o = head & (&chain_q);
  assign div_o    = chain_q[STAGES-1];
endmodule

// File: rtl/dmp_prescaler_chk.sv
module dmp_prescaler_chk #(
  parameter int unsigned STAGES = dmp_pkg::DMP_STAGES
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mc_i,
  input logic div_o,
  input logic period_o
);
  localparam logic [7:0] LEN_BASE = 8'(2 ** (STAGES + 1));
  localparam logic [7:0] HALF     = 8'(2 ** STAGES);

  logic [7:0] len_q, hi_q, lo_q;
  logic       started_q, mp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= 8'd0;
      hi_q      <= 8'd0;
      lo_q      <= 8'd0;
      started_q <= 1'b0;
      mp_q      <= 1'b0;
    end else begin
      len_q <= period_o ? 8'd1 : len_q + 8'd1;
      hi_q  <= div_o ? hi_q + 8'd1 : 8'd0;
      lo_q  <= div_o ? 8'd0 : lo_q + 8'd1;
      if (period_o) begin
        started_q <= 1'b1;
        mp_q      <= mc_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (div_o && period_o);
  end

  // R6 and R8: the mode is taken at each strobe, including the first one after reset
  assert_len16_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o && started_q && !mp_q) |-> (len_q == LEN_BASE));

  assert_len17_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o && started_q && mp_q) |-> (len_q == LEN_BASE + 8'd1));

  assert_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_o) |-> (hi_q == HALF));

  assert_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o && started_q) |-> (lo_q == HALF + {7'd0, mp_q}));

  assert_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> period_o);

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o);
endmodule

bind dmp_prescaler dmp_prescaler_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/dmp_prescaler_test.sv
module dmp_prescaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mc, expected period length}
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b0, 5'd16}, {1'b0, 5'd16}, {1'b1, 5'd17}, {1'b1, 5'd17},
    {1'b0, 5'd16}, {1'b1, 5'd17}, {1'b0, 5'd16}, {1'b1, 5'd17}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc = 1'b0;
  logic div_w, period_w;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmp_prescaler uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .mc_i     (mc),
    .div_o    (div_w),
    .period_o (period_w)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge inside a strobe cycle; returns at the next one.
  task automatic run_period(input logic mc_start, input logic mc_mid, input int mid_at,
                            input int exp_len, input string len_tag);
    int n = 1, hi = 1, lo = 0;
    logic prev_div = 1'b1;
    check(period_w == 1'b1, "R7", int'(period_w), 1);
    mc = mc_start;
    while (n < 64) begin
      @(negedge clk);
      if (period_w) break;
      n++;
      if (div_w) hi++; else lo++;
      prev_div = div_w;
      if (mid_at != 0 && n == mid_at) mc = mc_mid;
    end
    check(n == exp_len, len_tag, n, exp_len);
    check(hi == 8, "R4", hi, 8);
    check(lo == exp_len - 8, "R5", lo, exp_len - 8);
    check(prev_div == 1'b0 && div_w == 1'b1, "R7", int'({prev_div, div_w}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mc = 1'b1;
    repeat (3) @(negedge clk);
    check(div_w == 1'b1, "R1", int'(div_w), 1);
    check(period_w == 1'b1, "R1", int'(period_w), 1);
    rst_n = 1'b1;
    // R8: first period after release in 17 mode
    run_period(1'b1, 1'b1, 0, 17, "R8");

    for (int i = 0; i < NVEC; i++) begin
      run_period(VEC[i][5], VEC[i][5], 0, int'(VEC[i][4:0]), VEC[i][5] ? "R3" : "R2");
    end

    // R6: late change is deferred to the next period
    run_period(1'b0, 1'b1, 5, 16, "R6");
    run_period(1'b1, 1'b1, 0, 17, "R6");
    run_period(1'b1, 1'b0, 12, 17, "R6");
    run_period(1'b0, 1'b0, 0, 16, "R6");

    // R1: asynchronous reset in the low half of a period
    repeat (11) @(negedge clk);
    check(div_w == 1'b0, "R5", int'(div_w), 0);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check(div_w == 1'b1, "R1", int'(div_w), 1);
    check(period_w == 1'b1, "R1", int'(period_w), 1);
    mc = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_period(1'b0, 1'b0, 0, 16, "R8");
    run_period(1'b1, 1'b1, 0, 17, "R3");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule